// File: doc/BRIEF.md
# Latched Input Port with Change Interrupt

This block holds the input side of a general-purpose I/O expander. It takes synchronized pin levels and compares each input-direction bit with a reference level. The reference is the level seen at the most recent read of the input port. Any difference makes that bit pending, and an active-low interrupt output is driven by the OR of all unmasked pending bits.

Each bit can be set to latched capture. A latched bit that changes stores its new level and stays pending even if the pin goes back before the port is read. Such a bit returns the stored level on the next read. A non-latched bit always returns its live level, and it stops being pending once the pin returns to the reference level.

A one-cycle read strobe marks a read of the input port. On the same clock edge it samples the returned value, reloads every reference level from the pins and clears every stored capture. The direction, latch-enable and mask bits are held in plain registers. They are written through a single write port with a select code.

Top module: `latched_input_port`

## Requirements
- R1: While reset is held, all bits are inputs, latch enables are 0, all bits are masked and `int_n` is 1. The reference levels follow the pins during reset, so if the pins are stable no bit is pending after reset, even once all masks are cleared. A read right after reset returns the pin levels.
- R2: A bit whose direction is output (direction bit 0) never becomes pending and never captures, even if its latch enable is 1. A read returns its live pin level.
- R3: An unmasked non-latched input bit whose pin differs from its reference drives `int_n` low. If the pin returns to the reference before a read, that bit stops contributing and `int_n` goes back to 1.
- R4: An unmasked latched input bit whose pin changes stores the new level and drives `int_n` low. `int_n` stays low after the pin returns, and the next read returns the stored level.
- R5: A read clears every stored capture and reloads every reference level from the pins, so `int_n` returns to 1 when the pins are stable. The following read returns the live levels.
- R6: Suppose a latched bit and a non-latched bit change together and both return before a read. `int_n` stays low. The read shows only the latched bit's change, and it clears the interrupt.
- R7: Switching a bit from latched to non-latched keeps its pending capture, so `int_n` stays low. Reads of that bit then return the live pin level.
- R8: Switching a pending non-latched bit to latched makes it capture the differing level. A later read returns that captured level, even if the pin has returned by then.
- R9: A bit whose mask bit is 1 does not drive `int_n`. Clearing the mask while the bit is still pending drives `int_n` low.
- R10: `port_q` changes only on the clock edge where `rd_stb` is 1. `int_n` is registered: it reflects a pin change on the first clock edge after the change.
- R11: Configuration write select codes are: 0 = direction (1 = input), 1 = latch enable (1 = latched), 2 = interrupt mask (1 = masked). Code 3 writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | WIDTH | Synchronized pin levels |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 2 | Configuration register select (0 direction, 1 latch enable, 2 mask) |
| cfg_wdata | input | WIDTH | Configuration write data |
| rd_stb | input | 1 | One-cycle strobe marking a read of the input port |
| port_q | output | WIDTH | Value returned by the most recent read |
| int_n | output | 1 | Active-low interrupt |

## Verification
The hardest state to reach is a capture that outlives the pin pulse that caused it, and then outlives a change of the bit's own configuration. In that state the pending interrupt no longer matches anything visible on the pins. The stimulus reaches it by pulsing a pin out and back while the bit is latched. It then rewrites the latch enable before issuing the read. It also covers the reverse order: it first makes a non-latched bit pending, and only then switches the bit to latched. Every bit is swept in both modes so that each cell's capture and self-clear paths are exercised.

// File: rtl/lip_pkg.sv
package lip_pkg;
  typedef enum logic [1:0] {
    SEL_DIR   = 2'd0,
    SEL_LATCH = 2'd1,
    SEL_MASK  = 2'd2,
    SEL_NONE  = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/lip_cfg_regs.sv
module lip_cfg_regs
  import lip_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [1:0]       sel,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] dir_o,
  output logic [WIDTH-1:0] latch_o,
  output logic [WIDTH-1:0] mask_o
);
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  cfg_sel_e sel_e;
  assign sel_e = cfg_sel_e'(sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_o   <= ALL_ONES;
      latch_o <= '0;
      mask_o  <= ALL_ONES;
    end else if (we) begin
      case (sel_e)
        SEL_DIR:   dir_o   <= wdata;
        SEL_LATCH: latch_o <= wdata;
        SEL_MASK:  mask_o  <= wdata;
        default:   ;
      endcase
    end
  end

  AST_RESET_MASKED: assert property (@(posedge clk) rst |=> (mask_o == ALL_ONES)); // R1
  AST_NONE_SEL_NOP: assert property (@(posedge clk) disable iff (rst)
    (we && sel == 2'd3) |=> ($stable(dir_o) && $stable(latch_o) && $stable(mask_o))); // R11
endmodule

// File: rtl/lip_bit_cell.sv
module lip_bit_cell (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic dir_in,
  input  logic latch_en,
  input  logic rd,
  output logic pend_o,
  output logic rdval_o
);
  logic ref_q;
  logic held_q;
  logic cap_q;
  logic moved;

  assign moved = pin ^ ref_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q  <= pin;
      held_q <= 1'b0;
      cap_q  <= 1'b0;
    end else if (rd) begin
      ref_q  <= pin;
      held_q <= 1'b0;
    end else if (dir_in && latch_en && !held_q && moved) begin
      held_q <= 1'b1;
      cap_q  <= pin;
    end
  end

  assign rdval_o = (latch_en && held_q) ? cap_q : pin;
  assign pend_o  = dir_in && (held_q || moved);

  AST_HELD_PERSISTS: assert property (@(posedge clk) disable iff (rst)
    (held_q && !rd) |=> held_q); // R4
  AST_HELD_VALUE: assert property (@(posedge clk) disable iff (rst)
    (held_q && !rd) |=> $stable(cap_q)); // R4
  AST_READ_RELEASES: assert property (@(posedge clk) disable iff (rst)
    rd |=> !held_q); // R5
  AST_OUTPUT_NO_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (!dir_in && !held_q) |=> !held_q); // R2
endmodule

// File: rtl/lip_int_out.sv
module lip_int_out #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pend_i,
  input  logic [WIDTH-1:0] mask_i,
  input  logic             rd,
  input  logic [WIDTH-1:0] rdval_i,
  output logic             int_n_o,
  output logic [WIDTH-1:0] port_o
);
  logic any_live;
  assign any_live = |(pend_i & ~mask_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      int_n_o <= 1'b1;
      port_o  <= '0;
    end else begin
      int_n_o <= ~any_live;
      if (rd) port_o <= rdval_i;
    end
  end

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (&mask_i) |=> int_n_o); // R9
  AST_PORT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd |=> $stable(port_o)); // R10
endmodule

// File: rtl/latched_input_port.sv
module latched_input_port #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pin_i,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [WIDTH-1:0] cfg_wdata,
  input  logic             rd_stb,
  output logic [WIDTH-1:0] port_q,
  output logic             int_n
);
  logic [WIDTH-1:0] dir_r, latch_r, mask_r;
  logic [WIDTH-1:0] pend, rdval;

  lip_cfg_regs #(.WIDTH(WIDTH)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .dir_o(dir_r), .latch_o(latch_r), .mask_o(mask_r)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    lip_bit_cell u_cell (
      .clk(clk), .rst(rst), .pin(pin_i[i]), .dir_in(dir_r[i]),
      .latch_en(latch_r[i]), .rd(rd_stb),
      .pend_o(pend[i]), .rdval_o(rdval[i])
    );
  end

  lip_int_out #(.WIDTH(WIDTH)) u_out (
    .clk(clk), .rst(rst), .pend_i(pend), .mask_i(mask_r), .rd(rd_stb),
    .rdval_i(rdval), .int_n_o(int_n), .port_o(port_q)
  );

  AST_RESET_INT_IDLE: assert property (@(posedge clk) rst |=> int_n); // R1
endmodule

// File: tb/latched_input_port_bench.sv
module latched_input_port_bench;
  localparam int W = 8;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] pin = 8'hA5;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = 2'd0;
  logic [W-1:0] cfg_wdata = '0;
  logic rd_stb = 1'b0;
  logic [W-1:0] port_q;
  logic int_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  latched_input_port #(.WIDTH(W)) u_latched_input_port (
    .clk(clk), .rst(rst), .pin_i(pin), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .rd_stb(rd_stb), .port_q(port_q), .int_n(int_n)
  );

  task automatic tick(int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(string req, logic [W-1:0] got, logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [1:0] s, logic [W-1:0] d);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic rd(output logic [W-1:0] v);
    rd_stb = 1'b1;
    tick();
    rd_stb = 1'b0;
    v = port_q;
    tick();
  endtask

  logic [W-1:0] v, base, bitm, held;

  initial begin
    tick(3);
    chk("R1 int idle in reset", {7'd0, int_n}, 8'd1);
    rst = 1'b0;
    tick(2);
    chk("R1 int after reset", {7'd0, int_n}, 8'd1);
    wr(2'd2, 8'h00);
    tick(2);
    chk("R1 no spurious int", {7'd0, int_n}, 8'd1);
    rd(v);
    chk("R1 read after reset", v, 8'hA5);

    // R11 select 3 writes nothing: mask stays clear, toggle must interrupt
    wr(2'd3, 8'hFF);
    pin = pin ^ 8'h01;
    tick(2);
    chk("R11 sel3 ignored", {7'd0, int_n}, 8'd0);
    pin = pin ^ 8'h01;
    tick(2);

    // R10 int_n registered, one edge after change
    pin = pin ^ 8'h10;
    chk("R10 int before edge", {7'd0, int_n}, 8'd1);
    tick();
    chk("R10 int after one edge", {7'd0, int_n}, 8'd0);
    chk("R10 port_q holds without read", port_q, 8'hA5);
    pin = pin ^ 8'h10;
    tick(2);

    // Sweep each bit in both modes (R3, R4, R5)
    for (int b = 0; b < W; b++) begin
      for (int lat = 0; lat < 2; lat++) begin
        bitm = 8'h01 << b;
        wr(2'd1, lat ? bitm : 8'h00);
        rd(v);
        base = pin;
        pin = base ^ bitm;
        tick(2);
        chk(lat ? "R4 raise" : "R3 raise", {7'd0, int_n}, 8'd0);
        pin = base;
        tick(2);
        chk(lat ? "R4 held after return" : "R3 self-clear", {7'd0, int_n},
            lat ? 8'd0 : 8'd1);
        rd(v);
        chk(lat ? "R4 read captured" : "R3 read live", v, lat ? (base ^ bitm) : base);
        tick();
        chk("R5 int cleared by read", {7'd0, int_n}, 8'd1);
        rd(v);
        chk("R5 second read live", v, base);
      end
    end

    // R9 mask per bit
    wr(2'd1, 8'h00);
    for (int b = 0; b < W; b++) begin
      bitm = 8'h01 << b;
      wr(2'd2, bitm);
      base = pin;
      pin = base ^ bitm;
      tick(2);
      chk("R9 masked quiet", {7'd0, int_n}, 8'd1);
      wr(2'd2, 8'h00);
      tick();
      chk("R9 unmask shows pending", {7'd0, int_n}, 8'd0);
      pin = base;
      tick(2);
    end

    // R2 output bits
    wr(2'd1, 8'hFF);
    wr(2'd0, 8'hF7);
    rd(v);
    base = pin;
    pin = base ^ 8'h08;
    tick(2);
    chk("R2 output bit no int", {7'd0, int_n}, 8'd1);
    rd(v);
    chk("R2 output bit reads live", v, base ^ 8'h08);
    pin = base;
    tick();
    wr(2'd0, 8'hFF);
    rd(v);

    // R6 mixed latched bit 2 and non-latched bit 5
    wr(2'd1, 8'h04);
    rd(v);
    base = pin;
    pin = base ^ 8'h24;
    tick(2);
    pin = base;
    tick(2);
    chk("R6 int stays", {7'd0, int_n}, 8'd0);
    rd(v);
    chk("R6 read shows latched only", v, base ^ 8'h04);
    tick();
    chk("R6 int cleared", {7'd0, int_n}, 8'd1);

    // R7 latched -> non-latched keeps pending, reads live
    wr(2'd1, 8'h08);
    rd(v);
    base = pin;
    pin = base ^ 8'h08;
    tick(2);
    pin = base;
    tick(2);
    wr(2'd1, 8'h00);
    tick(2);
    chk("R7 pending kept", {7'd0, int_n}, 8'd0);
    rd(v);
    chk("R7 reads live", v, base);
    tick();
    chk("R7 cleared by read", {7'd0, int_n}, 8'd1);

    // R8 non-latched pending -> latched captures
    rd(v);
    base = pin;
    pin = base ^ 8'h40;
    tick(2);
    wr(2'd1, 8'h40);
    tick(2);
    pin = base;
    tick(2);
    chk("R8 int held", {7'd0, int_n}, 8'd0);
    rd(v);
    held = base ^ 8'h40;
    chk("R8 reads latched level", v, held);
    tick();
    chk("R8 cleared", {7'd0, int_n}, 8'd1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule